// File: doc/BRIEF.md
# Stretchable-Read Memory Target Controller

This block runs the bus cycles of a 32-bit synchronous memory target on a shared local bus. A master opens a cycle by presenting an address strobe along with the word address, direction, byte enables and a last-transfer flag. The controller counts a configurable number of wait states, waits out any refresh that is still busy, and then answers with a one-clock `ready`. On reads it drives the data bus. On writes it stores the master's data on the clock edge that closes the `ready` cycle. Bursts repeat the wait-and-ready sequence once per word. The word address steps up by one on each beat, and the cycle closes on the beat that carries last-transfer.

A slow master doing a single-word read can stretch the data phase by holding `extend`. While `extend` is held, `ready` and the read data stay unchanged on the bus. The cycle closes on the first clock edge that samples `extend` low. `extend` is not allowed in a burst or a write. In those cases the controller raises a one-clock protocol-error flag, ignores the request and completes the cycle as normal. A request/grant pair arbitrates the bus for an expansion master. After a grant is withdrawn, a release interval passes before the bus can be granted again, so that the previous owner has time to float its control lines. The memory array is a small register-based stub.

Top module: `strd_mem_target`

## Requirements
- R1: While reset is applied and on the first clock after it, `ready`, `rdata_oe`, `proto_err` and `bus_gnt` are all low.
- R2: If `refresh_busy` stays low, `ready` first goes high WAIT_STATES+1 clock edges after the edge that samples `strobe` high. A cycle that is not extended holds `ready` high for exactly one clock.
- R3: In a single read (`last_xfer`=1, `wr_nrd`=0) with `extend` high on the edge that ends the `ready` clock, `ready` and `rdata` stay unchanged. The cycle ends on the first edge that samples `extend` low, and `ready` falls there.
- R4: When the wait count expires, `ready` is withheld until a clock edge samples `refresh_busy` low, and it rises on that edge.
- R5: An edge that samples `extend` high during a cycle's wait or `ready` clock, with `wr_nrd`=1 or `last_xfer`=0, sets `proto_err` for the next clock. That `extend` is ignored: the cycle completes with a single-clock `ready`.
- R6: A write stores each byte lane i (bits 8i+7..8i) of `wdata` whose `byte_en[i]` was high at the strobe. The store happens on the edge that ends the `ready` clock, and lanes that are not enabled keep their value. A later read of that word returns the merged value. The array resets to zero.
- R7: A burst (`last_xfer`=0 at the `ready` edge) gives one `ready` pulse per beat. Each following beat addresses the next word, modulo the array depth. The burst ends on the beat whose `ready` edge samples `last_xfer` high.
- R8: On reads, `rdata_oe` rises together with the first `ready`. It stays high for the rest of the cycle and falls one clock after the cycle-ending edge.
- R9: `bus_gnt` is a registered copy of `bus_req`. After `bus_gnt` falls, it stays low for RELEASE_CYC further clocks even if `bus_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus request from the expansion master |
| bus_gnt | output | 1 | Registered bus grant |
| strobe | input | 1 | Address strobe that opens a cycle |
| last_xfer | input | 1 | High on the final (or only) transfer |
| wr_nrd | input | 1 | 1 = write, 0 = read |
| byte_en | input | 4 | Byte-lane enables, bit i for lane i |
| word_addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| extend | input | 1 | Request to stretch a single read's data phase |
| refresh_busy | input | 1 | Refresh in progress; blocks completion |
| rdata | output | 32 | Read data |
| rdata_oe | output | 1 | Read data output enable |
| ready | output | 1 | Transfer acknowledge |
| proto_err | output | 1 | One-clock flag for illegal use of `extend` |

## Verification
The bench drives a stretched read and checks that the data bus stays constant for every held clock. A design that reloads the data from the array, or drops `ready` early, fails this check. It holds `refresh_busy` past the point where the wait count expires and measures the `ready` latency. A controller that ignored refresh would answer too early. It asserts `extend` during a write and during a read burst and expects the error flag together with normal completion. A design that honoured `extend` there would hang or skip the flag. It also drops a grant while the request stays high, to expose a re-grant that ignores the release interval.

// File: rtl/strd_pkg.sv
package strd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2,
    ST_HOLD = 2'd3
  } cyc_state_t;

  localparam int LANES  = 4;
  localparam int WORD_W = 8 * LANES;

  function automatic logic [WORD_W-1:0] merge_lanes(
    input logic [WORD_W-1:0] old_word,
    input logic [WORD_W-1:0] new_word,
    input logic [LANES-1:0]  lane_en
  );
    logic [WORD_W-1:0] res;
    res = old_word;
    for (int i = 0; i < LANES; i++) begin
      if (lane_en[i]) res[8*i +: 8] = new_word[8*i +: 8];
    end
    return res;
  endfunction

endpackage

// File: rtl/strd_wait_timer.sv
module strd_wait_timer #(
  parameter int WAIT_STATES = 1,
  localparam int CNT_W = $clog2(WAIT_STATES + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= CNT_W'(WAIT_STATES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/strd_word_store.sv
module strd_word_store
  import strd_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANES-1:0]  lane_en,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[addr] <= merge_lanes(mem_q[addr], wdata, lane_en);
    end
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/strd_bus_arbiter.sv
module strd_bus_arbiter #(
  parameter int RELEASE_CYC = 2,
  localparam int REL_W = $clog2(RELEASE_CYC + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic gnt
);
  logic             gnt_q;
  logic [REL_W-1:0] rel_q;
  logic             release_busy;

  assign release_busy = (rel_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q <= 1'b0;
      rel_q <= '0;
    end else if (gnt_q) begin
      if (!req) begin
        gnt_q <= 1'b0;
        rel_q <= REL_W'(RELEASE_CYC);
      end
    end else if (release_busy) begin
      rel_q <= rel_q - 1'b1;
    end else begin
      gnt_q <= req;
    end
  end

  assign gnt = gnt_q;

  assert_grant_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_q) |-> $past(req));

  generate
    if (RELEASE_CYC > 0) begin : g_rel_check
      assert_no_quick_regrant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gnt_q) |=> !gnt_q);
    end
  endgenerate
endmodule

// File: rtl/strd_mem_target.sv
module strd_mem_target
  import strd_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int WAIT_STATES = 1,
  parameter int RELEASE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  output logic              bus_gnt,
  input  logic              strobe,
  input  logic              last_xfer,
  input  logic              wr_nrd,
  input  logic [3:0]        byte_en,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic [31:0]       wdata,
  input  logic              extend,
  input  logic              refresh_busy,
  output logic [31:0]       rdata,
  output logic              rdata_oe,
  output logic              ready,
  output logic              proto_err
);
  cyc_state_t        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_inc;
  logic              wr_q;
  logic [3:0]        be_q;
  logic [31:0]       rdata_q, store_rdata;
  logic              ready_q, oe_q, err_q;
  logic              timer_expired;

  // Named internal events
  logic strobe_take, wait_done, in_ack, in_hold, in_wait;
  logic hold_go, hold_exit, beat_next, ext_illegal, store_we, timer_load;

  assign in_wait     = (state_q == ST_WAIT);
  assign in_ack      = (state_q == ST_ACK);
  assign in_hold     = (state_q == ST_HOLD);
  assign strobe_take = (state_q == ST_IDLE) && strobe;
  assign wait_done   = in_wait && timer_expired && !refresh_busy;
  assign hold_go     = in_ack && !wr_q && last_xfer && extend;
  assign hold_exit   = in_hold && !extend;
  assign beat_next   = in_ack && !last_xfer;
  assign ext_illegal = (in_wait || in_ack) && extend && (wr_q || !last_xfer);
  assign store_we    = in_ack && wr_q;
  assign timer_load  = strobe_take || beat_next;
  assign addr_inc    = addr_q + 1'b1;

  strd_wait_timer #(.WAIT_STATES(WAIT_STATES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (timer_load),
    .expired (timer_expired)
  );

  strd_word_store #(.ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (store_we),
    .addr    (addr_q),
    .wdata   (wdata),
    .lane_en (be_q),
    .rdata   (store_rdata)
  );

  strd_bus_arbiter #(.RELEASE_CYC(RELEASE_CYC)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (bus_req),
    .gnt   (bus_gnt)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (strobe_take) state_d = ST_WAIT;
      ST_WAIT: if (wait_done)   state_d = ST_ACK;
      ST_ACK: begin
        if (hold_go)        state_d = ST_HOLD;
        else if (beat_next) state_d = ST_WAIT;
        else                state_d = ST_IDLE;
      end
      ST_HOLD: if (hold_exit) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      be_q    <= '0;
      rdata_q <= '0;
      ready_q <= 1'b0;
      oe_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= ext_illegal;
      ready_q <= wait_done || hold_go || (in_hold && extend);
      if (strobe_take) begin
        addr_q <= word_addr;
        wr_q   <= wr_nrd;
        be_q   <= byte_en;
      end else if (beat_next) begin
        addr_q <= addr_inc;
      end
      if (wait_done && !wr_q) rdata_q <= store_rdata;
      if (state_q == ST_IDLE)      oe_q <= 1'b0;
      else if (wait_done && !wr_q) oe_q <= 1'b1;
    end
  end

  assign rdata     = rdata_q;
  assign rdata_oe  = oe_q;
  assign ready     = ready_q;
  assign proto_err = err_q;

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ack && !hold_go) |=> !ready);
  assert_hold_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_hold |-> (ready && rdata_oe));
  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && $past(in_hold)) |-> $stable(rdata));
  assert_refresh_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && refresh_busy) |=> !ready);
  assert_err_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_illegal |=> proto_err);
  assert_no_write_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_hold |-> !wr_q);
  assert_burst_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_next |=> (addr_q == $past(addr_inc)));
  assert_oe_with_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !wr_q) |-> rdata_oe);
endmodule

// File: tb/strd_mem_target_tb.sv
module strd_mem_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 4;
  localparam int WAITS = 1;
  localparam int REL   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 1'b0, strobe = 1'b0, last_xfer = 1'b1, wr_nrd = 1'b0;
  logic [3:0] byte_en = 4'hF;
  logic [AW-1:0] word_addr = '0;
  logic [31:0] wdata = '0;
  logic extend = 1'b0, refresh_busy = 1'b0;
  logic bus_gnt, rdata_oe, ready, proto_err;
  logic [31:0] rdata;

  int checks = 0, failures = 0, err_seen = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  strd_mem_target #(.ADDR_W(AW), .WAIT_STATES(WAITS), .RELEASE_CYC(REL)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .strobe(strobe), .last_xfer(last_xfer), .wr_nrd(wr_nrd), .byte_en(byte_en),
    .word_addr(word_addr), .wdata(wdata), .extend(extend),
    .refresh_busy(refresh_busy), .rdata(rdata), .rdata_oe(rdata_oe),
    .ready(ready), .proto_err(proto_err)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_phase = 0, m_cnt = 0, m_addr = 0, m_gnt = 0, m_rel = 0;
  bit m_wr = 0, m_ready = 0, m_oe = 0, m_err = 0;
  logic [3:0] m_be = 0;
  logic [31:0] m_rdata = 0;
  logic [31:0] m_mem [16];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_addr = 0; m_wr = 0; m_be = 0;
      m_ready = 0; m_oe = 0; m_err = 0; m_rdata = 0; m_gnt = 0; m_rel = 0;
      foreach (m_mem[i]) m_mem[i] = 0;
    end else begin
      m_err = (m_phase == 1 || m_phase == 2) && extend && (m_wr || !last_xfer);
      case (m_phase)
        0: begin
          m_oe = 0;
          if (strobe) begin
            m_addr = int'(word_addr); m_wr = wr_nrd; m_be = byte_en;
            m_cnt = WAITS; m_phase = 1;
          end
        end
        1: begin
          if (m_cnt > 0) m_cnt--;
          else if (!refresh_busy) begin
            m_phase = 2; m_ready = 1;
            if (!m_wr) begin m_rdata = m_mem[m_addr]; m_oe = 1; end
          end
        end
        2: begin
          if (m_wr)
            for (int b = 0; b < 4; b++)
              if (m_be[b]) m_mem[m_addr][8*b +: 8] = wdata[8*b +: 8];
          if (!m_wr && last_xfer && extend) m_phase = 3;
          else if (last_xfer) begin m_phase = 0; m_ready = 0; end
          else begin m_addr = (m_addr + 1) % 16; m_cnt = WAITS; m_phase = 1; m_ready = 0; end
        end
        default: if (!extend) begin m_phase = 0; m_ready = 0; end
      endcase
      if (m_gnt != 0) begin
        if (!bus_req) begin m_gnt = 0; m_rel = REL; end
      end else if (m_rel > 0) m_rel--;
      else m_gnt = int'(bus_req);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, "ready", ready, m_ready);
      check(cur_req, "rdata_oe", rdata_oe, m_oe);
      check(cur_req, "proto_err", proto_err, m_err);
      check("R9", "bus_gnt", bus_gnt, m_gnt);
      if (m_oe) check(cur_req, "rdata", rdata, m_rdata);
      if (proto_err) err_seen++;
    end
  end

  function automatic logic [31:0] wpat(input int a, input int k);
    return 32'h5A000000 ^ (a << 12) ^ (k * 32'h00010203) ^ 32'h0000C3C3;
  endfunction

  task automatic run_cycle(input int addr, input bit wr, input logic [3:0] be,
                           input int beats, input bit ext, input int hold_len,
                           input int ref_len, output int lat, output int rdy_cnt,
                           output logic [31:0] rd_first, output bit rd_moved);
    int n = 0;
    @(negedge clk);
    strobe = 1; word_addr = AW'(addr); wr_nrd = wr; byte_en = be;
    last_xfer = (beats == 1); extend = ext; refresh_busy = (ref_len > 0);
    wdata = wpat(addr, 0);
    lat = 0; rdy_cnt = 0; rd_first = '0; rd_moved = 0;
    forever begin
      @(negedge clk);
      n++; strobe = 0;
      if (n >= ref_len) refresh_busy = 0;
      wdata = wpat(addr, rdy_cnt);
      if (n > 80) begin
        check(cur_req, "cycle timeout", n, 0);
        break;
      end
      if (ready) begin
        if (rdy_cnt == 0) begin lat = n; rd_first = rdata; end
        else if (rdata != rd_first && beats == 1) rd_moved = 1;
        rdy_cnt++;
        if (beats == 1) begin
          if (ext && !wr && rdy_cnt < hold_len) continue;
          if (!wr) extend = 0;
          break;
        end else begin
          extend = 0;
          if (rdy_cnt == beats) break;
        end
      end else if (beats > 1) begin
        last_xfer = (rdy_cnt == beats - 1);
      end
    end
  endtask

  task automatic finish_cycle();
    @(negedge clk);
    extend = 0; last_xfer = 1; strobe = 0; refresh_busy = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lat, rc, e0;
    logic [31:0] rf;
    bit mv;
    repeat (3) @(negedge clk);
    check("R1", "ready in reset", ready, 0);
    check("R1", "oe in reset", rdata_oe, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1", "ready after reset", ready, 0);
    check("R1", "err after reset", proto_err, 0);
    check("R1", "gnt after reset", bus_gnt, 0);

    cur_req = "R6";
    run_cycle(3, 1, 4'hF, 1, 0, 0, 0, lat, rc, rf, mv); finish_cycle();
    run_cycle(5, 1, 4'b0101, 1, 0, 0, 0, lat, rc, rf, mv); finish_cycle();
    run_cycle(5, 0, 4'hF, 1, 0, 0, 0, lat, rc, rf, mv); finish_cycle();
    check("R6", "lane merge read", rf, wpat(5, 0) & 32'h00FF00FF);

    cur_req = "R2";
    run_cycle(3, 0, 4'hF, 1, 0, 0, 0, lat, rc, rf, mv);
    check("R2", "ready latency", lat, WAITS + 2);
    check("R2", "ready width", rc, 1);
    cur_req = "R8";
    finish_cycle();
    check("R8", "oe one clock after end", rdata_oe, 1);
    check("R8", "ready low after end", ready, 0);
    @(negedge clk);
    check("R8", "oe dropped", rdata_oe, 0);

    cur_req = "R3";
    run_cycle(3, 0, 4'hF, 1, 1, 4, 0, lat, rc, rf, mv); finish_cycle();
    check("R3", "held ready clocks", rc, 4);
    check("R3", "data moved during hold", mv, 0);
    check("R3", "held data value", rf, wpat(3, 0));

    cur_req = "R4";
    run_cycle(5, 0, 4'hF, 1, 0, 0, 7, lat, rc, rf, mv); finish_cycle();
    check("R4", "refresh latency", lat, ((WAITS + 1 > 7) ? WAITS + 1 : 7) + 1);

    cur_req = "R5";
    e0 = err_seen;
    run_cycle(8, 1, 4'hF, 1, 1, 0, 0, lat, rc, rf, mv); finish_cycle();
    check("R5", "write extend flagged", int'(err_seen > e0), 1);
    check("R5", "write extend ignored", rc, 1);
    run_cycle(8, 0, 4'hF, 1, 0, 0, 0, lat, rc, rf, mv); finish_cycle();
    check("R5", "write completed", rf, wpat(8, 0));

    cur_req = "R7";
    e0 = err_seen;
    run_cycle(14, 1, 4'hF, 3, 0, 0, 0, lat, rc, rf, mv); finish_cycle();
    check("R7", "write burst beats", rc, 3);
    run_cycle(14, 0, 4'hF, 3, 1, 0, 0, lat, rc, rf, mv); finish_cycle();
    check("R7", "read burst beats", rc, 3);
    check("R5", "burst extend flagged", int'(err_seen > e0), 1);
    run_cycle(0, 0, 4'hF, 1, 0, 0, 0, lat, rc, rf, mv); finish_cycle();
    check("R7", "wrapped beat word", rf, wpat(14, 2));

    cur_req = "R9";
    @(negedge clk); bus_req = 1;
    @(negedge clk);
    check("R9", "grant follows request", bus_gnt, 1);
    bus_req = 0;
    @(negedge clk);
    check("R9", "grant withdrawn", bus_gnt, 0);
    bus_req = 1;
    for (int i = 0; i < REL; i++) begin
      @(negedge clk);
      check("R9", "grant held off", bus_gnt, 0);
    end
    @(negedge clk);
    check("R9", "grant after release", bus_gnt, 1);
    bus_req = 0;
    repeat (4) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule